// File: doc/BRIEF.md
# Linear Quantizer with Table Dequantizer

This block sits beside a neuron evaluation engine that works in two passes. In the first pass, the engine makes a partial result for every neuron over a whole sequence. Each partial result is a signed fixed-point value, and the quantize path turns it into an 8-bit signed code so it can be stored cheaply. In the second pass, the engine reads the codes back. The dequantize path turns each code into a number again by looking it up in a table that software fills at configuration time.

The quantize path multiplies the magnitude of the input by a scale constant. Software computes this constant ahead of time, from an assumed largest partial magnitude of about 20 (scale ≈ 127/20). The path then rounds half away from zero, clamps the result to ±127 and puts the sign back. The path is pipelined over two stages and takes a new sample on every cycle, so it never stalls the engine that feeds it. The table has 256 entries. It is written through a plain address/data/write-enable port, and it answers a lookup one cycle later.

Top module: `lqd_codec`

## Requirements
- R1: While rst_ni is low, q_valid_o and dq_valid_o are 0, and q_code_o and dq_data_o are 0.
- R2: q_valid_o equals q_valid_i delayed by exactly two clock cycles. A new sample is accepted on every cycle with no stall.
- R3: For input x (two's complement, IN_FRAC = 16 fraction bits) and scale s (unsigned, SCALE_FRAC = 12 fraction bits), the code magnitude is floor((|x|·s + 2^27) / 2^28). This rounds half away from zero. The code takes the sign of x, so code(−x) = −code(x).
- R4: When the rounded magnitude exceeds 127, the code is +127 (0x7F) or −127 (0x81). The code 0x80 (−128) is never produced.
- R5: An input of zero always gives code 0, whatever the scale.
- R6: When tbl_we_i is high at a clock edge, tbl_data_i is stored in the table entry selected by tbl_addr_i.
- R7: dq_valid_o equals dq_valid_i delayed by one cycle. When it is high, dq_data_o is the table entry indexed by the unsigned 8-bit code that was presented with dq_valid_i.
- R8: When a lookup and a write hit the same entry in the same cycle, the lookup returns the old contents. A lookup in the following cycle returns the new value.
- R9: In a cycle where q_valid_o is low, q_code_o keeps its previous value. In a cycle where dq_valid_o is low, dq_data_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scale_i | input | 16 | Quantization scale, unsigned, 12 fraction bits |
| q_valid_i | input | 1 | Partial value valid |
| q_data_i | input | 24 | Partial value, signed, 16 fraction bits |
| q_valid_o | output | 1 | Code valid |
| q_code_o | output | 8 | Signed 8-bit code |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 8 | Table write address |
| tbl_data_i | input | 24 | Table write data |
| dq_valid_i | input | 1 | Lookup request valid |
| dq_code_i | input | 8 | Code to look up |
| dq_valid_o | output | 1 | Lookup result valid |
| dq_data_o | output | 24 | Table value for the requested code |

## Verification
The assertions check the valid latencies of both paths on every cycle. They also check that the code 0x80 never appears, that the sign of each code matches its input, that zero maps to zero, and that both outputs hold when their valid is low. Only the bench's scenarios can show the exact rounded values. These include the exact half-way points on both sides of zero, saturation at the extreme inputs, table contents after loading, and read-before-write order when a lookup and a write hit the same entry.

// File: rtl/lqd_pkg.sv
package lqd_pkg;
  localparam int unsigned CODE_W  = 8;
  localparam int unsigned TBL_DEP = 1 << CODE_W;

  // magnitude limit keeps the code range symmetric
  localparam int unsigned QMAX = (1 << (CODE_W - 1)) - 1;

  typedef logic signed [CODE_W-1:0] code_t;

  function automatic code_t apply_sign(input logic neg, input logic [CODE_W-2:0] mag);
    code_t m;
    m = code_t'({1'b0, mag});
    return neg ? -m : m;
  endfunction
endpackage

// File: rtl/lqd_qmul.sv
module lqd_qmul #(
  parameter int unsigned IN_W    = 24,
  parameter int unsigned SCALE_W = 16,
  localparam int unsigned PROD_W = IN_W + SCALE_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [IN_W-1:0]   data_i,
  input  logic [SCALE_W-1:0]       scale_i,
  output logic                     valid_o,
  output logic                     neg_o,
  output logic [PROD_W-1:0]        prod_o
);
  logic              neg;
  logic [IN_W-1:0]   mag;
  logic [PROD_W-1:0] prod;

  always_comb begin
    neg  = data_i[IN_W-1];
    // unsigned magnitude also covers the most negative input
    mag  = neg ? IN_W'(-data_i) : IN_W'(data_i);
    prod = PROD_W'(mag) * PROD_W'(scale_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      neg_o   <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        neg_o  <= neg;
        prod_o <= prod;
      end
    end
  end
endmodule

// File: rtl/lqd_qrnd.sv
module lqd_qrnd
  import lqd_pkg::*;
#(
  parameter int unsigned PROD_W    = 40,
  parameter int unsigned PROD_FRAC = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              neg_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic              valid_o,
  output code_t             code_o
);
  localparam logic [PROD_W:0] HALF = (PROD_W + 1)'(1) << (PROD_FRAC - 1);
  localparam logic [PROD_W:0] LIM  = (PROD_W + 1)'(QMAX);

  logic [PROD_W:0]   rnd_sum;
  logic [PROD_W:0]   rnd_mag;
  logic [CODE_W-2:0] clp_mag;
  code_t             code_d;

  always_comb begin
    rnd_sum = {1'b0, prod_i} + HALF;
    rnd_mag = rnd_sum >> PROD_FRAC;
    clp_mag = (rnd_mag > LIM) ? (CODE_W - 1)'(QMAX) : rnd_mag[CODE_W-2:0];
    code_d  = apply_sign(neg_i, clp_mag);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= code_d;
    end
  end
endmodule

// File: rtl/lqd_tbl.sv
module lqd_tbl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 24,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rvalid_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read samples the array before this edge's write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rvalid_i;
      if (rvalid_i) rdata_o <= mem[raddr_i];
    end
  end
endmodule

// File: rtl/lqd_codec.sv
module lqd_codec
  import lqd_pkg::*;
#(
  parameter int unsigned IN_W       = 24,
  parameter int unsigned IN_FRAC    = 16,
  parameter int unsigned SCALE_W    = 16,
  parameter int unsigned SCALE_FRAC = 12,
  parameter int unsigned DATA_W     = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SCALE_W-1:0]     scale_i,
  input  logic                   q_valid_i,
  input  logic signed [IN_W-1:0] q_data_i,
  output logic                   q_valid_o,
  output logic [CODE_W-1:0]      q_code_o,
  input  logic                   tbl_we_i,
  input  logic [CODE_W-1:0]      tbl_addr_i,
  input  logic [DATA_W-1:0]      tbl_data_i,
  input  logic                   dq_valid_i,
  input  logic [CODE_W-1:0]      dq_code_i,
  output logic                   dq_valid_o,
  output logic [DATA_W-1:0]      dq_data_o
);
  localparam int unsigned PROD_W    = IN_W + SCALE_W;
  localparam int unsigned PROD_FRAC = IN_FRAC + SCALE_FRAC;

  logic              s1_valid;
  logic              s1_neg;
  logic [PROD_W-1:0] s1_prod;
  code_t             s2_code;

  lqd_qmul #(.IN_W(IN_W), .SCALE_W(SCALE_W)) u_qmul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (q_valid_i),
    .data_i  (q_data_i),
    .scale_i (scale_i),
    .valid_o (s1_valid),
    .neg_o   (s1_neg),
    .prod_o  (s1_prod)
  );

  lqd_qrnd #(.PROD_W(PROD_W), .PROD_FRAC(PROD_FRAC)) u_qrnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .neg_i   (s1_neg),
    .prod_i  (s1_prod),
    .valid_o (q_valid_o),
    .code_o  (s2_code)
  );

  assign q_code_o = s2_code;

  lqd_tbl #(.ADDR_W(CODE_W), .DATA_W(DATA_W)) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we_i),
    .waddr_i  (tbl_addr_i),
    .wdata_i  (tbl_data_i),
    .rvalid_i (dq_valid_i),
    .raddr_i  (dq_code_i),
    .rvalid_o (dq_valid_o),
    .rdata_o  (dq_data_o)
  );
endmodule

// File: rtl/lqd_codec_chk.sv
module lqd_codec_chk #(
  parameter int unsigned IN_W   = 24,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned DATA_W = 24
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   q_valid_i,
  input logic signed [IN_W-1:0] q_data_i,
  input logic                   q_valid_o,
  input logic [CODE_W-1:0]      q_code_o,
  input logic                   dq_valid_i,
  input logic                   dq_valid_o,
  input logic [DATA_W-1:0]      dq_data_o
);
  localparam logic [CODE_W-1:0] MIN_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_i |=> ##1 q_valid_o);
  a_r2_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_valid_i |=> ##1 !q_valid_o);
  a_r3_sign_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_valid_i && q_data_i[IN_W-1]) |=> ##1 (q_code_o[CODE_W-1] || q_code_o == '0));
  a_r3_sign_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_valid_i && !q_data_i[IN_W-1]) |=> ##1 !q_code_o[CODE_W-1]);
  a_r4_no_min_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |-> q_code_o != MIN_CODE);
  a_r5_zero_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_valid_i && q_data_i == '0) |=> ##1 (q_code_o == '0));
  a_r7_dq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_valid_i |=> dq_valid_o);
  a_r7_dq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_valid_i |=> !dq_valid_o);
  a_r9_q_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_valid_o |-> $stable(q_code_o));
  a_r9_dq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_valid_o |-> $stable(dq_data_o));
endmodule

bind lqd_codec lqd_codec_chk #(
  .IN_W   (IN_W),
  .CODE_W (lqd_pkg::CODE_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .q_valid_i  (q_valid_i),
  .q_data_i   (q_data_i),
  .q_valid_o  (q_valid_o),
  .q_code_o   (q_code_o),
  .dq_valid_i (dq_valid_i),
  .dq_valid_o (dq_valid_o),
  .dq_data_o  (dq_data_o)
);

// File: tb/lqd_codec_tb_top.sv
`timescale 1ns/1ps
module lqd_codec_tb_top;
  localparam int IN_W = 24;
  localparam int DATA_W = 24;
  localparam longint ONE_IN = 64'sd65536;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       scale = 16'd4096;
  logic              q_valid = 1'b0;
  logic signed [IN_W-1:0] q_data = '0;
  logic              q_valid_o;
  logic [7:0]        q_code_o;
  logic              tbl_we = 1'b0;
  logic [7:0]        tbl_addr = '0;
  logic [DATA_W-1:0] tbl_data = '0;
  logic              dq_valid = 1'b0;
  logic [7:0]        dq_code = '0;
  logic              dq_valid_o;
  logic [DATA_W-1:0] dq_data_o;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b0;
  int phase6 = 0;

  always #10 clk = ~clk;

  lqd_codec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scale_i(scale),
    .q_valid_i(q_valid), .q_data_i(q_data),
    .q_valid_o(q_valid_o), .q_code_o(q_code_o),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
    .dq_valid_i(dq_valid), .dq_code_i(dq_code),
    .dq_valid_o(dq_valid_o), .dq_data_o(dq_data_o)
  );

  // R3/R4: round half away from zero, clamp to +-127
  function automatic int qmodel(longint x, longint s);
    longint m, r;
    m = (x < 0) ? -x : x;
    r = (m * s + (64'sd1 <<< 27)) >>> 28;
    if (r > 127) r = 127;
    return (x < 0) ? -int'(r) : int'(r);
  endfunction

  task automatic check(bit ok, int req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected-value pipeline derived from R2, R7, R8, R9
  logic [DATA_W-1:0] tbl_m [256];
  bit v1, v2, dv;
  int c1, ecode, t1, etag, edq_tag;
  logic [DATA_W-1:0] edq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 0; v2 <= 0; dv <= 0; ecode <= 0; edq <= '0;
      c1 <= 0; t1 <= 3; etag <= 1; edq_tag <= 1;
    end else begin
      v1 <= q_valid;
      if (q_valid) begin
        c1 <= qmodel(longint'(q_data), longint'(scale));
        t1 <= (q_data == 0) ? 5 : ((qmodel(longint'(q_data), longint'(scale)) inside {127, -127}) ? 4 : 3);
      end
      v2 <= v1;
      if (v1) begin ecode <= c1; etag <= t1; end else etag <= 9;
      dv <= dq_valid;
      if (dq_valid) begin
        edq <= tbl_m[dq_code];
        // R8 collision, R6 load readback, else R7
        edq_tag <= (tbl_we && tbl_addr == dq_code) ? 8 : (phase6 != 0 ? 6 : 7);
      end else edq_tag <= 9;
      if (tbl_we) tbl_m[tbl_addr] <= tbl_data;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(q_valid_o == v2, 2, "q_valid_o", q_valid_o, v2);
      check($signed(q_code_o) == ecode, etag, "q_code_o", $signed(q_code_o), ecode);
      check(dq_valid_o == dv, 7, "dq_valid_o", dq_valid_o, dv);
      check(dq_data_o == edq, edq_tag, "dq_data_o", dq_data_o, edq);
    end
  end

  task automatic qdrive(bit v, longint x);
    @(negedge clk);
    q_valid = v; q_data = IN_W'(x);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk);
    // R1: reset values
    check(q_valid_o == 1'b0, 1, "q_valid_o in reset", q_valid_o, 0);
    check(q_code_o == 8'h00, 1, "q_code_o in reset", q_code_o, 0);
    check(dq_valid_o == 1'b0, 1, "dq_valid_o in reset", dq_valid_o, 0);
    check(dq_data_o == '0, 1, "dq_data_o in reset", dq_data_o, 0);
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R6: load the whole table, then read it back
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 8'(i); tbl_data = DATA_W'($urandom);
    end
    @(negedge clk); tbl_we = 1'b0; phase6 = 1;
    for (int i = 0; i < 256; i++) begin
      dq_valid = 1'b1; dq_code = 8'(255 - i);
      @(negedge clk);
    end
    dq_valid = 1'b0; phase6 = 0;

    // R3/R5: exact halves and symmetry at unit scale
    scale = 16'd4096;
    qdrive(1, 0);
    qdrive(1, 5 * ONE_IN / 2);
    qdrive(1, -5 * ONE_IN / 2);
    qdrive(0, 0);
    qdrive(1, 5 * ONE_IN / 2 - 1);
    qdrive(1, -(5 * ONE_IN / 2 - 1));
    qdrive(1, ONE_IN / 2);
    qdrive(1, -ONE_IN / 2);
    qdrive(1, ONE_IN / 2 - 1);
    qdrive(0, 0);
    qdrive(0, 0);
    // R4: saturation with a scale built for max magnitude 20
    scale = 16'd26010;
    qdrive(1, 20 * ONE_IN);
    qdrive(1, 41 * ONE_IN / 2);
    qdrive(1, -41 * ONE_IN / 2);
    qdrive(1, -(64'sd1 <<< 23));
    qdrive(1, (64'sd1 <<< 23) - 1);
    qdrive(1, -20 * ONE_IN);
    scale = 16'hFFFF;
    qdrive(1, 0);
    qdrive(0, 0);

    // R8: write and lookup the same entry in one cycle, then again
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 8'd5; tbl_data = 24'hA5A5A5;
    dq_valid = 1'b1; dq_code = 8'd5;
    @(negedge clk);
    tbl_we = 1'b0; dq_valid = 1'b1; dq_code = 8'd5;
    @(negedge clk);
    dq_valid = 1'b0;

    // random mix of everything, R2/R3/R7/R9
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 63) == 0) scale = 16'($urandom_range(1000, 32000));
      q_valid = ($urandom_range(0, 3) != 0);
      q_data = IN_W'($urandom_range(0, 3000000)) - IN_W'(1500000);
      if ($urandom_range(0, 15) == 0) q_data = '0;
      tbl_we = ($urandom_range(0, 7) == 0);
      tbl_addr = 8'($urandom);
      tbl_data = DATA_W'($urandom);
      dq_valid = ($urandom_range(0, 2) != 0);
      dq_code = ($urandom_range(0, 3) == 0) ? tbl_addr : 8'($urandom);
    end
    @(negedge clk);
    q_valid = 1'b0; tbl_we = 1'b0; dq_valid = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule